// File: doc/BRIEF.md
# Conversion Result Register Pair with Read Interlock

This block stores the most recent 10-bit conversion result. A processor reads it through an 8-bit bus as two byte-wide registers at adjacent addresses. A separate control register holds one bit that picks the alignment of the result inside the 16-bit pair. The alignment can be left, with the top bits in the high byte, or right, with the top bits in the low end of the high byte. Alignment is applied when the pair is read, so flipping the control bit re-maps the stored value at once.

A new result arrives with a single-cycle completion strobe. A result spread over two bytes must read as one value. For this reason, a read of the low byte locks the visible pair. Results that complete while the pair is locked go to a one-deep pending slot, and only the newest is kept. The high-byte read releases the lock and moves the pending result in. A read of the high byte alone never locks, so software that needs only eight bits of a left-aligned result can skip the low byte. Read data is combinational from the address and the visible pair.

Top module: `adcr_result_regs`

## Requirements
- R1: After reset, reads of the low byte (0x19), the high byte (0x1A) and the control register (0x1C) all return 0x00, and right alignment is in force.
- R2: With the alignment bit clear, the high byte reads result[9:8] in bits 1:0 with bits 7:2 zero, and the low byte reads result[7:0].
- R3: With the alignment bit set, the high byte reads result[9:2], and the low byte reads result[1:0] in bits 7:6 with bits 5:0 zero.
- R4: Control register bit 7 is the alignment bit, and a write to 0x1C stores it. Bits 6:0 always read zero, whatever is written to them.
- R5: A change of the alignment bit shows in the next read of either byte, with no new result needed. This holds while the pair is locked.
- R6: When the pair is not locked, a result presented with the completion strobe is readable from the cycle after the strobe.
- R7: From a low-byte read until the following high-byte read, no completed result changes the visible pair. This includes a result whose strobe falls in the same cycle as the low-byte read.
- R8: On the high-byte read that ends a lock, the newest result that completed during the lock becomes visible from the next cycle. Older results from the same lock are discarded.
- R9: A high-byte read with no low-byte read before it does not lock the pair, and later results update it normally.
- R10: A result whose strobe falls in the same cycle as the unlocking high-byte read becomes visible and takes precedence over any pending result.
- R11: A read of any address other than 0x19, 0x1A or 0x1C returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Single-cycle conversion-complete strobe |
| res_data | input | 10 | Conversion result, sampled with res_valid |
| bus_addr | input | 6 | Register address |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
The bench targets the following corner cases:
- **Lock cycle.** It delivers two results while the pair is locked. A design that lets results through shows a torn pair. A design that keeps the first pending result shows a stale value after the high read.
- **Same-cycle strobes.** It lines up a completion strobe with the locking low read, and another with the unlocking high read. An off-by-one lock shows the wrong byte in the first case. A design that prefers the pending slot in the second case shows the older value.
- **High-only read.** It reads the high byte alone and then delivers a new result. This catches a lock that sets on any read.
- **Alignment changes.** It flips alignment while locked, and it writes ones to the unused control bits. This catches alignment that is latched at capture time and control bits that are stored when they should not be.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  // Which register the bus address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/adcr_decode.sv
module adcr_decode
  import adcr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LO_ADDR   = 'h19,
  parameter int CTRL_ADDR = 'h1C
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(LO_ADDR + 1);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  always_comb begin
    if (addr == LO_A)        sel = SEL_LO;
    else if (addr == HI_A)   sel = SEL_HI;
    else if (addr == CTRL_A) sel = SEL_CTRL;
    else                     sel = SEL_NONE;
  end
endmodule

// File: rtl/adcr_ctrl.sv
module adcr_ctrl #(
  parameter int DATA_W    = 8,
  parameter int ALIGN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              align
);
  // Only the alignment bit is storable; every other bit stays zero
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(1) << ALIGN_BIT;

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & KEEP;
  end

  assign align = ctrl_q[ALIGN_BIT];
endmodule

// File: rtl/adcr_lock.sv
module adcr_lock #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             lo_rd,
  input  logic             hi_rd,
  output logic [RES_W-1:0] vis_q,
  output logic             locked_q
);
  logic [RES_W-1:0] pend_q;
  logic             pend_v_q;
  logic             freeze;

  // Pair frozen on the locking read itself and for every locked cycle
  // except the one carrying the releasing high-byte read.
  assign freeze = lo_rd | (locked_q & ~hi_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
    end else if (lo_rd) begin
      locked_q <= 1'b1;
    end else if (hi_rd) begin
      locked_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (freeze) begin
      if (res_valid) begin
        pend_q   <= res_data;  // newest wins
        pend_v_q <= 1'b1;
      end
    end else begin
      if (res_valid)     vis_q <= res_data;
      else if (pend_v_q) vis_q <= pend_q;
      pend_v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adcr_align.sv
module adcr_align #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic [RES_W-1:0]    vis,
  input  logic                align,
  output logic [2*DATA_W-1:0] pair
);
  localparam int PAIR_W = 2 * DATA_W;
  localparam int PAD    = PAIR_W - RES_W;

  logic [PAIR_W-1:0] right_v;
  logic [PAIR_W-1:0] left_v;

  generate
    if (PAD == 0) begin : g_full
      assign right_v = vis;
      assign left_v  = vis;
    end else begin : g_pad
      assign right_v = {{PAD{1'b0}}, vis};
      assign left_v  = {vis, {PAD{1'b0}}};
    end
  endgenerate

  assign pair = align ? left_v : right_v;
endmodule

// File: rtl/adcr_result_regs.sv
module adcr_result_regs
  import adcr_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int LO_ADDR   = 'h19,
  parameter int CTRL_ADDR = 'h1C,
  parameter int ALIGN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAIR_W = 2 * DATA_W;

  reg_sel_e          sel;
  logic              lo_rd, hi_rd, ctrl_wr;
  logic [RES_W-1:0]  vis_q;
  logic              lock_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              align;
  logic [PAIR_W-1:0] pair;

  adcr_decode #(
    .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr(bus_addr), .sel(sel)
  );

  assign lo_rd   = bus_rd & (sel == SEL_LO);
  assign hi_rd   = bus_rd & (sel == SEL_HI);
  assign ctrl_wr = bus_wr & (sel == SEL_CTRL);

  adcr_ctrl #(
    .DATA_W(DATA_W), .ALIGN_BIT(ALIGN_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .align(align)
  );

  adcr_lock #(
    .RES_W(RES_W)
  ) u_lock (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .lo_rd(lo_rd), .hi_rd(hi_rd), .vis_q(vis_q), .locked_q(lock_q)
  );

  adcr_align #(
    .RES_W(RES_W), .DATA_W(DATA_W)
  ) u_align (
    .vis(vis_q), .align(align), .pair(pair)
  );

  always_comb begin
    unique case (sel)
      SEL_LO:   bus_rdata = pair[DATA_W-1:0];
      SEL_HI:   bus_rdata = pair[PAIR_W-1:DATA_W];
      SEL_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adcr_result_regs_chk.sv
module adcr_result_regs_chk #(
  parameter int RES_W     = 10,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int LO_ADDR   = 'h19,
  parameter int CTRL_ADDR = 'h1C
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [RES_W-1:0]  vis,
  input logic              locked,
  input logic              align
);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(LO_ADDR + 1);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic lo_rd, hi_rd;
  assign lo_rd = bus_rd && (bus_addr == LO_A);
  assign hi_rd = bus_rd && (bus_addr == HI_A);

  // R7: the pair holds from the low read until the releasing high read
  assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (lo_rd || (locked && !hi_rd)) |=> $stable(vis));

  // R7: a low-byte read engages the lock
  assert_lock_set_R7: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> locked);

  // R8 and R9: a high-byte read always leaves the pair unlocked
  assert_unlock_R8: assert property (@(posedge clk) disable iff (rst)
    hi_rd |=> !locked);

  // R6: an unlocked capture appears next cycle
  assert_update_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !locked && !lo_rd) |=> (vis == $past(res_data)));

  // R10: a capture on the releasing read beats the pending slot
  assert_newest_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && locked && hi_rd) |=> (vis == $past(res_data)));

  // R4: unused control bits read zero
  assert_ctrl_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == CTRL_A) |-> (bus_rdata[DATA_W-2:0] == '0));

  // R2: right alignment leaves upper high-byte bits zero
  assert_hi_pad_R2: assert property (@(posedge clk) disable iff (rst)
    (!align && bus_addr == HI_A) |-> (bus_rdata[DATA_W-1:RES_W-DATA_W] == '0));

  // R3: left alignment leaves lower low-byte bits zero
  assert_lo_pad_R3: assert property (@(posedge clk) disable iff (rst)
    (align && bus_addr == LO_A) |-> (bus_rdata[2*DATA_W-RES_W-1:0] == '0));
endmodule

bind adcr_result_regs adcr_result_regs_chk #(
  .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .LO_ADDR(LO_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .vis(vis_q), .locked(lock_q), .align(align)
);

// File: tb/test_adcr_result_regs.sv
`timescale 1ns/1ps
module test_adcr_result_regs;
  localparam logic [5:0] A_LO = 6'h19, A_HI = 6'h1A, A_CTRL = 6'h1C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic [5:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  adcr_result_regs i_adcr_result_regs (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Reference formatting from R2/R3
  function automatic logic [7:0] ref_hi(logic [9:0] r, bit left);
    return left ? r[9:2] : {6'b0, r[9:8]};
  endfunction
  function automatic logic [7:0] ref_lo(logic [9:0] r, bit left);
    return left ? {r[1:0], 6'b0} : r[7:0];
  endfunction

  // Driver: one read cycle, optionally with a result strobe in the same cycle
  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t,
                    input bit with_res = 1'b0, input logic [9:0] r = '0);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    res_valid = with_res; res_data = r;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0; res_valid = 1'b0; bus_addr = 6'h00;
  endtask

  task automatic push_res(input logic [9:0] r);
    @(negedge clk);
    res_valid = 1'b1; res_data = r;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    bus_addr = A_CTRL; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 6'h00;
  endtask

  // Monitor: compares each read against the front of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_rd) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s addr %02h: actual %02h expected %02h", t, bus_addr, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_LO,   8'h00, "R1");
    rd(A_HI,   8'h00, "R1");
    rd(A_CTRL, 8'h00, "R1");
    // R6 and R2: unlocked capture, right aligned
    push_res(10'h2A5);
    rd(A_HI, ref_hi(10'h2A5, 0), "R2");
    rd(A_LO, ref_lo(10'h2A5, 0), "R2");
    rd(A_HI, ref_hi(10'h2A5, 0), "R6");
    // R9: high-only read does not lock
    rd(A_HI, ref_hi(10'h2A5, 0), "R9");
    push_res(10'h155);
    rd(A_HI, ref_hi(10'h155, 0), "R9");
    // R7: locked pair ignores two results; R8: newest pending appears
    rd(A_LO, ref_lo(10'h155, 0), "R7");
    push_res(10'h3FF);
    push_res(10'h0F0);
    rd(A_HI, ref_hi(10'h155, 0), "R7");
    rd(A_LO, ref_lo(10'h0F0, 0), "R8");
    rd(A_HI, ref_hi(10'h0F0, 0), "R8");
    // R4: only bit 7 stored
    wr_ctrl(8'hFF);
    rd(A_CTRL, 8'h80, "R4");
    // R5 and R3: stored value re-mapped without a new result
    rd(A_HI, ref_hi(10'h0F0, 1), "R5");
    rd(A_LO, ref_lo(10'h0F0, 1), "R5");
    rd(A_HI, ref_hi(10'h0F0, 1), "R3");
    push_res(10'h2A5);
    rd(A_HI, ref_hi(10'h2A5, 1), "R3");
    rd(A_LO, ref_lo(10'h2A5, 1), "R3");
    // R5 while locked: clear alignment between the two reads
    wr_ctrl(8'h7F);
    rd(A_CTRL, 8'h00, "R4");
    rd(A_HI, ref_hi(10'h2A5, 0), "R5");
    // R7: strobe in the same cycle as the locking read
    rd(A_LO, ref_lo(10'h2A5, 0), "R7", 1'b1, 10'h111);
    rd(A_HI, ref_hi(10'h2A5, 0), "R7");
    rd(A_LO, ref_lo(10'h111, 0), "R8");
    // R10: strobe on the releasing read beats the pending one
    push_res(10'h222);
    rd(A_HI, ref_hi(10'h111, 0), "R10", 1'b1, 10'h333);
    rd(A_LO, ref_lo(10'h333, 0), "R10");
    rd(A_HI, ref_hi(10'h333, 0), "R10");
    // R11: unmapped addresses
    rd(6'h00, 8'h00, "R11");
    rd(6'h1B, 8'h00, "R11");
    rd(6'h3F, 8'h00, "R11");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule